// File: doc/BRIEF.md
# NAND Page Layout Sequencer

This block walks the byte positions of one physical NAND page and tells the datapath what each byte is. A page is laid out as a short metadata field owned by packet 0, followed by every data packet with its ECC field right after it. A bad-block-marker area of configurable length sits at a fixed physical offset. That offset lands inside the data of the final packet, so the final packet is split: first part, marker bytes, remaining data, then the final ECC field.

A single start pulse in the idle state latches the configuration: packet count, per-packet data size, metadata size, ECC strength, marker offset and marker length. The sequencer then presents one byte position at a time. For each position it gives a region tag, the packet index and the offset within the region. Whoever consumes the byte raises `accept`, and the sequencer moves to the next position on that clock edge. The ECC field length is derived from the strength with a field order of 15. No ECC arithmetic or flash bus timing lives here.

Top module: `page_layout_seq`

## Requirements
- R1: While reset is asserted and after it is released without a start, `valid` and `last` are low.
- R2: A `start` pulse while idle latches all configuration inputs. `valid` is high on the next cycle, presenting the first byte.
- R3: The first `cfg_meta` bytes carry tag META (code 0), packet index 0 and offsets 0 upward. When `cfg_meta` is 0 the page starts directly with packet 0 data.
- R4: Each packet's data bytes carry tag DATA (code 1) with offsets 0 to `cfg_pkt`-1. They are followed by that packet's ECC bytes, tag ECC (code 2), with offsets from 0. The packet index advances by one only after a packet's last ECC byte.
- R5: The ECC field is ceil(`cfg_strength` × 15 / 8) bytes long.
- R6: The marker area starts at the physical byte position `cfg_mark_off`, counted from 0 over every byte of the page. It consists of `cfg_mark_len` bytes with tag MARK (code 3), offsets 0 upward, and the last packet's index. The data that follows it continues the data offset where it stopped. The last packet's ECC field comes after that data.
- R7: When the marker offset equals the end of the last packet's data, the marker bytes are followed directly by the last ECC field.
- R8: `last` is high only on the final ECC byte of the last packet. After that byte is accepted, `valid` is low.
- R9: While `valid` is high and `accept` is low, every output holds its value.
- R10: A `start` pulse while a page is in progress is ignored, and so are configuration input changes during that page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a page when idle |
| cfg_steps | input | STEP_W | Number of packets in the page |
| cfg_meta | input | META_W | Metadata byte count |
| cfg_pkt | input | SIZE_W | Data bytes per packet |
| cfg_strength | input | STR_W | ECC strength |
| cfg_mark_off | input | SIZE_W | Physical byte offset of the marker area |
| cfg_mark_len | input | MARK_W | Marker area length in bytes |
| accept | input | 1 | Current byte consumed; advance |
| valid | output | 1 | A byte position is presented |
| tag | output | 2 | Region: 0 META, 1 DATA, 2 ECC, 3 MARK |
| pkt_idx | output | STEP_W | Packet index of the current byte |
| offset | output | SIZE_W | Offset within the current region |
| last | output | 1 | Final byte of the page |

## Verification
The checker assumes a legal geometry. The packet count, data size, strength and marker length are at least one. The marker offset falls inside the last packet's data, anywhere from its first byte up to the byte just past its end. The checker also assumes `accept` is only meaningful while `valid` is high. The bench keeps within these limits by deriving every marker offset from the other fields: it places the marker 1 to `cfg_pkt` bytes into the last packet. It sweeps all small combinations of the other fields under an accept pattern with regular stalls. During each page it pulses `start` again and drives out-of-range configuration values, which the sequencer must ignore.

// File: rtl/page_layout_pkg.sv
package page_layout_pkg;

    typedef enum logic [1:0] {
        TAG_META = 2'd0,
        TAG_DATA = 2'd1,
        TAG_ECC  = 2'd2,
        TAG_MARK = 2'd3
    } tag_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_META,
        S_DATA,
        S_ECC,
        S_MARK,
        S_TAIL,
        S_LECC
    } state_e;

    localparam int FIELD_ORDER = 15;

endpackage

// File: rtl/page_layout_cfg.sv
module page_layout_cfg #(
    parameter int STEP_W = 8,
    parameter int META_W = 8,
    parameter int SIZE_W = 16,
    parameter int STR_W  = 8,
    parameter int MARK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [STEP_W-1:0] in_steps,
    input  logic [META_W-1:0] in_meta,
    input  logic [SIZE_W-1:0] in_pkt,
    input  logic [STR_W-1:0]  in_strength,
    input  logic [SIZE_W-1:0] in_mark_off,
    input  logic [MARK_W-1:0] in_mark_len,
    output logic [STEP_W-1:0] steps_q,
    output logic [META_W-1:0] meta_q,
    output logic [SIZE_W-1:0] pkt_q,
    output logic [STR_W-1:0]  strength_q,
    output logic [SIZE_W-1:0] mark_off_q,
    output logic [MARK_W-1:0] mark_len_q
);

    typedef struct packed {
        logic [STEP_W-1:0] steps;
        logic [META_W-1:0] meta;
        logic [SIZE_W-1:0] pkt;
        logic [STR_W-1:0]  strength;
        logic [SIZE_W-1:0] mark_off;
        logic [MARK_W-1:0] mark_len;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load) begin
            cfg_d.steps    = in_steps;
            cfg_d.meta     = in_meta;
            cfg_d.pkt      = in_pkt;
            cfg_d.strength = in_strength;
            cfg_d.mark_off = in_mark_off;
            cfg_d.mark_len = in_mark_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign steps_q    = cfg_q.steps;
    assign meta_q     = cfg_q.meta;
    assign pkt_q      = cfg_q.pkt;
    assign strength_q = cfg_q.strength;
    assign mark_off_q = cfg_q.mark_off;
    assign mark_len_q = cfg_q.mark_len;

endmodule

// File: rtl/page_layout_ecclen.sv
module page_layout_ecclen
    import page_layout_pkg::*;
#(
    parameter int STR_W = 8,
    parameter int ECC_W = STR_W + 1
) (
    input  logic [STR_W-1:0] strength,
    output logic [ECC_W-1:0] ecc_len
);

    // strength * 15 needs four extra bits; rounding up adds 7 before the shift
    localparam int PROD_W = STR_W + 4;

    logic [PROD_W-1:0] product;
    logic [PROD_W-1:0] rounded;

    always_comb begin
        product = PROD_W'(strength) * PROD_W'(FIELD_ORDER);
        rounded = product + PROD_W'(7);
        ecc_len = ECC_W'(rounded >> 3);
    end

endmodule

// File: rtl/page_layout_seq.sv
module page_layout_seq
    import page_layout_pkg::*;
#(
    parameter int STEP_W = 8,
    parameter int META_W = 8,
    parameter int SIZE_W = 16,
    parameter int STR_W  = 8,
    parameter int MARK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [STEP_W-1:0] cfg_steps,
    input  logic [META_W-1:0] cfg_meta,
    input  logic [SIZE_W-1:0] cfg_pkt,
    input  logic [STR_W-1:0]  cfg_strength,
    input  logic [SIZE_W-1:0] cfg_mark_off,
    input  logic [MARK_W-1:0] cfg_mark_len,
    input  logic              accept,
    output logic              valid,
    output logic [1:0]        tag,
    output logic [STEP_W-1:0] pkt_idx,
    output logic [SIZE_W-1:0] offset,
    output logic              last
);

    localparam int ECC_W = STR_W + 1;
    localparam int POS_W = SIZE_W + 1;

    typedef struct packed {
        state_e            st;
        logic [STEP_W-1:0] pkt;
        logic [SIZE_W-1:0] off;
        logic [MARK_W-1:0] moff;
        logic [POS_W-1:0]  pos;
        logic              mdone;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              load;
    logic              fire;
    logic [STEP_W-1:0] steps_q;
    logic [META_W-1:0] meta_q;
    logic [SIZE_W-1:0] pkt_q;
    logic [STR_W-1:0]  strength_q;
    logic [SIZE_W-1:0] mark_off_q;
    logic [MARK_W-1:0] mark_len_q;
    logic [ECC_W-1:0]  ecc_len;

    logic [SIZE_W-1:0] meta_end;
    logic [SIZE_W-1:0] pkt_end;
    logic [SIZE_W-1:0] ecc_end;
    logic [MARK_W-1:0] mark_end;
    logic [STEP_W-1:0] last_pkt;
    logic              hit_mark;

    assign load = (seq_q.st == S_IDLE) && start;
    assign fire = (seq_q.st != S_IDLE) && accept;

    page_layout_cfg #(
        .STEP_W(STEP_W), .META_W(META_W), .SIZE_W(SIZE_W),
        .STR_W(STR_W),   .MARK_W(MARK_W)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .in_steps    (cfg_steps),
        .in_meta     (cfg_meta),
        .in_pkt      (cfg_pkt),
        .in_strength (cfg_strength),
        .in_mark_off (cfg_mark_off),
        .in_mark_len (cfg_mark_len),
        .steps_q     (steps_q),
        .meta_q      (meta_q),
        .pkt_q       (pkt_q),
        .strength_q  (strength_q),
        .mark_off_q  (mark_off_q),
        .mark_len_q  (mark_len_q)
    );

    page_layout_ecclen #(.STR_W(STR_W), .ECC_W(ECC_W)) u_ecclen (
        .strength (strength_q),
        .ecc_len  (ecc_len)
    );

    always_comb begin
        meta_end = SIZE_W'(meta_q) - SIZE_W'(1);
        pkt_end  = pkt_q - SIZE_W'(1);
        ecc_end  = SIZE_W'(ecc_len) - SIZE_W'(1);
        mark_end = mark_len_q - MARK_W'(1);
        last_pkt = steps_q - STEP_W'(1);
        // the byte now presented sits at physical position pos; the marker
        // follows it when the next position equals the marker offset
        hit_mark = !seq_q.mdone && ((seq_q.pos + POS_W'(1)) == {1'b0, mark_off_q});
    end

    always_comb begin
        seq_d = seq_q;
        if (load) begin
            seq_d.st    = (cfg_meta == '0) ? S_DATA : S_META;
            seq_d.pkt   = '0;
            seq_d.off   = '0;
            seq_d.moff  = '0;
            seq_d.pos   = '0;
            seq_d.mdone = 1'b0;
        end else if (fire) begin
            seq_d.pos = seq_q.pos + POS_W'(1);
            case (seq_q.st)
                S_META: begin
                    if (seq_q.off == meta_end) begin
                        seq_d.st  = S_DATA;
                        seq_d.off = '0;
                    end else begin
                        seq_d.off = seq_q.off + SIZE_W'(1);
                    end
                end
                S_DATA: begin
                    if (hit_mark) begin
                        seq_d.st   = S_MARK;
                        seq_d.off  = seq_q.off + SIZE_W'(1);
                        seq_d.moff = '0;
                    end else if (seq_q.off == pkt_end) begin
                        seq_d.st  = (seq_q.pkt == last_pkt) ? S_LECC : S_ECC;
                        seq_d.off = '0;
                    end else begin
                        seq_d.off = seq_q.off + SIZE_W'(1);
                    end
                end
                S_ECC: begin
                    if (seq_q.off == ecc_end) begin
                        seq_d.st  = S_DATA;
                        seq_d.pkt = seq_q.pkt + STEP_W'(1);
                        seq_d.off = '0;
                    end else begin
                        seq_d.off = seq_q.off + SIZE_W'(1);
                    end
                end
                S_MARK: begin
                    if (seq_q.moff == mark_end) begin
                        seq_d.mdone = 1'b1;
                        if (seq_q.off == pkt_q) begin
                            seq_d.st  = S_LECC;
                            seq_d.off = '0;
                        end else begin
                            seq_d.st = S_TAIL;
                        end
                    end else begin
                        seq_d.moff = seq_q.moff + MARK_W'(1);
                    end
                end
                S_TAIL: begin
                    if (seq_q.off == pkt_end) begin
                        seq_d.st  = S_LECC;
                        seq_d.off = '0;
                    end else begin
                        seq_d.off = seq_q.off + SIZE_W'(1);
                    end
                end
                S_LECC: begin
                    if (seq_q.off == ecc_end) begin
                        seq_d.st = S_IDLE;
                    end else begin
                        seq_d.off = seq_q.off + SIZE_W'(1);
                    end
                end
                default: seq_d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= S_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        valid   = (seq_q.st != S_IDLE);
        pkt_idx = seq_q.pkt;
        offset  = (seq_q.st == S_MARK) ? SIZE_W'(seq_q.moff) : seq_q.off;
        last    = (seq_q.st == S_LECC) && (seq_q.off == ecc_end);
        case (seq_q.st)
            S_META:         tag = TAG_META;
            S_ECC, S_LECC:  tag = TAG_ECC;
            S_MARK:         tag = TAG_MARK;
            default:        tag = TAG_DATA;
        endcase
    end

endmodule

// File: rtl/page_layout_seq_chk.sv
module page_layout_seq_chk #(
    parameter int STEP_W = 8,
    parameter int SIZE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              accept,
    input logic              valid,
    input logic [1:0]        tag,
    input logic [STEP_W-1:0] pkt_idx,
    input logic [SIZE_W-1:0] offset,
    input logic              last
);

    // R2
    idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && start) |=> valid);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !accept) |=> (valid && $stable(tag) && $stable(pkt_idx)
                                && $stable(offset) && $stable(last)));

    // R8
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && last && accept) |=> !valid);

    // R8
    last_is_ecc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> (valid && tag == 2'd2));

    // R10
    busy_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !last) |=> valid);

    // R4
    pkt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && $past(valid)) |->
            (pkt_idx == $past(pkt_idx) || pkt_idx == $past(pkt_idx) + STEP_W'(1)));

endmodule

bind page_layout_seq page_layout_seq_chk #(.STEP_W(STEP_W), .SIZE_W(SIZE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .accept  (accept),
    .valid   (valid),
    .tag     (tag),
    .pkt_idx (pkt_idx),
    .offset  (offset),
    .last    (last)
);

// File: tb/page_layout_seq_test.sv
module page_layout_seq_test;

    localparam int STEP_W = 8;
    localparam int META_W = 8;
    localparam int SIZE_W = 16;
    localparam int STR_W  = 8;
    localparam int MARK_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [STEP_W-1:0] cfg_steps = '0;
    logic [META_W-1:0] cfg_meta = '0;
    logic [SIZE_W-1:0] cfg_pkt = '0;
    logic [STR_W-1:0]  cfg_strength = '0;
    logic [SIZE_W-1:0] cfg_mark_off = '0;
    logic [MARK_W-1:0] cfg_mark_len = '0;
    logic              accept = 1'b0;
    logic              valid;
    logic [1:0]        tag;
    logic [STEP_W-1:0] pkt_idx;
    logic [SIZE_W-1:0] offset;
    logic              last;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    page_layout_seq #(
        .STEP_W(STEP_W), .META_W(META_W), .SIZE_W(SIZE_W),
        .STR_W(STR_W),   .MARK_W(MARK_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_steps(cfg_steps), .cfg_meta(cfg_meta), .cfg_pkt(cfg_pkt),
        .cfg_strength(cfg_strength), .cfg_mark_off(cfg_mark_off),
        .cfg_mark_len(cfg_mark_len), .accept(accept),
        .valid(valid), .tag(tag), .pkt_idx(pkt_idx), .offset(offset), .last(last)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected layout of byte k for the given geometry; a = first-part length
    task automatic model(input int k, input int steps, input int meta, input int pkt,
                         input int ecc, input int mk, input int a,
                         output int tg, output int p, output int o, output int l,
                         output string req);
        int j, r, body;
        body = (steps - 1) * (pkt + ecc);
        l = 0;
        if (k < meta) begin
            tg = 0; p = 0; o = k; req = "R3";
        end else begin
            j = k - meta;
            if (j < body) begin
                p = j / (pkt + ecc);
                r = j % (pkt + ecc);
                if (r < pkt) begin tg = 1; o = r; end
                else begin tg = 2; o = r - pkt; end
                req = "R4";
            end else begin
                p = steps - 1;
                r = j - body;
                if (r < a) begin tg = 1; o = r; req = "R6"; end
                else if (r < a + mk) begin tg = 3; o = r - a; req = (a == pkt) ? "R7" : "R6"; end
                else if (r < pkt + mk) begin tg = 1; o = r - mk; req = "R6"; end
                else begin
                    tg = 2; o = r - pkt - mk; req = "R5";
                    if (o == ecc - 1) l = 1;
                end
            end
        end
    endtask

    task automatic run_page(input int steps, input int meta, input int pkt,
                            input int str, input int mk, input int a, inout int cyc);
        int ecc, total, k, etg, ep, eo, el;
        string req;
        ecc = (str * 15 + 7) / 8;
        total = meta + steps * (pkt + ecc) + mk;
        @(negedge clk);
        cfg_steps    = STEP_W'(steps);
        cfg_meta     = META_W'(meta);
        cfg_pkt      = SIZE_W'(pkt);
        cfg_strength = STR_W'(str);
        cfg_mark_off = SIZE_W'(meta + (steps - 1) * (pkt + ecc) + a);
        cfg_mark_len = MARK_W'(mk);
        start = 1'b1;
        accept = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check(valid == 1'b1, "R2", "valid after start", int'(valid), 1);
        k = 0;
        while (k < total) begin
            model(k, steps, meta, pkt, ecc, mk, a, etg, ep, eo, el, req);
            check(valid == 1'b1, req, "valid", int'(valid), 1);
            check(int'(tag) == etg, req, "tag", int'(tag), etg);
            check(int'(pkt_idx) == ep, (req == "R3") ? "R3" : "R4", "pkt_idx", int'(pkt_idx), ep);
            check(int'(offset) == eo, req, "offset", int'(offset), eo);
            check(int'(last) == el, "R8", "last", int'(last), el);
            cyc++;
            accept = (cyc % 3) != 2;
            if (k == 1) begin
                // R10: restart attempt and garbage configuration mid-page
                start = 1'b1;
                cfg_steps = 8'd9; cfg_pkt = 16'd77; cfg_strength = 8'd40;
                cfg_meta = 8'd5; cfg_mark_off = 16'd3; cfg_mark_len = 8'd11;
            end else begin
                start = 1'b0;
            end
            if (!accept && k > 0) begin
                // R9: stalled byte is seen again next cycle
                @(negedge clk);
                start = 1'b0;
                check(int'(tag) == etg && int'(offset) == eo, "R9", "hold on stall",
                      int'(offset), eo);
                accept = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            if (accept) k++;
            accept = 1'b0;
        end
        check(valid == 1'b0, "R8", "valid after last byte", int'(valid), 0);
        check(last == 1'b0, "R10", "no restart from ignored start", int'(last), 0);
    endtask

    initial begin
        int cyc;
        cyc = 0;
        repeat (3) @(negedge clk);
        check(valid == 1'b0, "R1", "valid in reset", int'(valid), 0);
        check(last == 1'b0, "R1", "last in reset", int'(last), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(valid == 1'b0, "R1", "valid idle after reset", int'(valid), 0);
        accept = 1'b1;
        @(negedge clk);
        check(valid == 1'b0, "R1", "accept while idle", int'(valid), 0);
        accept = 1'b0;
        for (int steps = 1; steps <= 3; steps++)
            for (int meta = 0; meta <= 2; meta++)
                for (int pkt = 1; pkt <= 4; pkt++)
                    for (int str = 1; str <= 3; str++)
                        for (int mk = 1; mk <= 2; mk++)
                            for (int a = 1; a <= pkt; a++)
                                run_page(steps, meta, pkt, str, mk, a, cyc);
        // R5 with a larger strength: 17 * 15 = 255 -> 32 bytes of ECC
        run_page(1, 4, 3, 17, 6, 2, cyc);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule